// File: doc/BRIEF.md
# Per-Pixel First-Photon Statistics Accumulator

This block gathers timing statistics for a single photon-counting pixel and builds no histogram. It keeps two count/sum pairs. One pair holds background data, taken while the laser is off. The other holds data taken while the laser is on. In every enable window it takes the first timestamp that arrives and discards all later ones. This acquire-or-discard rule means every sample comes from a detector that was freshly re-armed. The accepted timestamp is added to the sum of the current phase, and that phase's event counter goes up by one.

A frame starts with a clear pulse. The frame then runs through as many off/on window pairs as the system wants, and the totals build up across all of them. An end pulse closes the frame. After the end pulse, a read-valid flag shows that the four totals are settled and may be read. Counters and sums saturate and do not wrap. A sticky overflow flag records any saturation.

The timestamp input is a valid-only stream with no back-pressure. The block can take one strobe in every cycle, so there is no ready signal. A strobe the block does not accept is dropped without any effect. The readout is plain level outputs, qualified by the read-valid flag.

Top module: `pixel_stat_accum`

## Requirements
- R1: Within one enable window (the stretch of cycles with `win_en` high), at most one strobe is accepted. Later strobes in the same window change no register until the next rising edge of `win_en`.
- R2: A strobe in the same cycle as the rising edge of `win_en` is accepted for the new window. The first strobe in any later cycle of that window is also accepted.
- R3: `laser_on` is sampled in the accept cycle. With 0 (laser off) the event updates only the background pair (`bg_cnt`, `bg_sum`). With 1 (laser on) it updates only the signal pair (`sig_cnt`, `sig_sum`).
- R4: Each accepted event raises its phase's count by one and adds `ts_data` to its phase's sum. The totals build up over all windows of a frame.
- R5: A `frame_clr` pulse clears all four registers and the overflow flag, drops `rd_valid` and starts a frame. `frame_clr` wins over a strobe in the same cycle, and that strobe is discarded.
- R6: Counts stop at 2^CNT_W-1 and sums stop at 2^SUM_W-1. Neither wraps.
- R7: `ovf` goes high when an accepted event finds its count already at full scale, or when the event's sum addition would exceed full scale. It stays high until the next `frame_clr`.
- R8: `frame_end` during a frame drives `rd_valid` high from the next cycle until `frame_clr`. While no frame is active, strobes are ignored and all registers hold.
- R9: After reset, all four registers and `ovf` are 0, `rd_valid` is 0 and no frame is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_clr | input | 1 | Pulse: clear the totals and start a frame |
| frame_end | input | 1 | Pulse: close the frame |
| win_en | input | 1 | Enable window of the current run |
| laser_on | input | 1 | Phase flag: 0 = background, 1 = signal |
| ts_valid | input | 1 | Timestamp strobe |
| ts_data | input | TS_W | Photon timestamp |
| bg_cnt | output | CNT_W | Background event count |
| bg_sum | output | SUM_W | Background timestamp sum |
| sig_cnt | output | CNT_W | Signal event count |
| sig_sum | output | SUM_W | Signal timestamp sum |
| ovf | output | 1 | Sticky saturation flag |
| rd_valid | output | 1 | Frame finished, totals readable |

## Verification
The bench runs over a narrow configuration and uses every timestamp value in both phases. Some windows carry extra strobes, which must be dropped, and others have a late first photon. A design that re-armed on every strobe would add the extra timestamps into the sums. A design that missed the edge-cycle photon would count too few events. A long run of signal events drives the count and the sum to full scale. A wrapping design would show small totals and no overflow, and a design with a leaky phase select would move data into the background pair. The bench also places a clear in the same cycle as a window-opening strobe, and it sends strobes after the frame has ended. A design that gave the wrong priority, or that did not freeze while idle, would change the totals.

// File: rtl/pixel_stat_pkg.sv
package pixel_stat_pkg;
  typedef enum logic {
    PH_BG  = 1'b0,
    PH_SIG = 1'b1
  } phase_e;
  localparam int NUM_PHASES = 2;
endpackage

// File: rtl/photon_gate.sv
module photon_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic active_i,
  input  logic en_i,
  input  logic valid_i,
  output logic accept_o
);
  logic en_q, armed_q, rise;

  assign rise     = en_i & ~en_q;
  assign accept_o = active_i & ~clr_i & valid_i & en_i & (rise | armed_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      en_q <= en_i;
      if (clr_i || accept_o) armed_q <= 1'b0;
      else if (rise)         armed_q <= 1'b1;
    end
  end

  // R1
  one_per_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> (!accept_o || (en_i && !$past(en_i))));
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic end_i,
  output logic active_o,
  output logic done_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      done_o   <= 1'b0;
    end else if (clr_i) begin
      active_o <= 1'b1;
      done_o   <= 1'b0;
    end else if (end_i && active_o) begin
      active_o <= 1'b0;
      done_o   <= 1'b1;
    end
  end

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !active_o);
endmodule

// File: rtl/stat_pair.sv
module stat_pair #(
  parameter int TS_W  = 16,
  parameter int CNT_W = 16,
  parameter int SUM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             hit_i,
  input  logic [TS_W-1:0]  ts_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [SUM_W-1:0] sum_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [SUM_W-1:0] SUM_MAX = '1;

  logic [SUM_W:0] sum_ext;
  logic           cnt_full, sum_carry;

  assign sum_ext   = {1'b0, sum_o} + {{(SUM_W + 1 - TS_W){1'b0}}, ts_i};
  assign cnt_full  = (cnt_o == CNT_MAX);
  assign sum_carry = sum_ext[SUM_W];
  assign sat_o     = hit_i & (cnt_full | sum_carry);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      sum_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
      sum_o <= '0;
    end else if (hit_i) begin
      if (!cnt_full) cnt_o <= cnt_o + 1'b1;
      sum_o <= sum_carry ? SUM_MAX : sum_ext[SUM_W-1:0];
    end
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i && !clr_i && cnt_o != CNT_MAX) |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
  // R6
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> cnt_o >= $past(cnt_o));
  // R6
  sum_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> sum_o >= $past(sum_o));
endmodule

// File: rtl/pixel_stat_accum.sv
module pixel_stat_accum
  import pixel_stat_pkg::*;
#(
  parameter int TS_W  = 16,
  parameter int CNT_W = 16,
  parameter int SUM_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_clr,
  input  logic             frame_end,
  input  logic             win_en,
  input  logic             laser_on,
  input  logic             ts_valid,
  input  logic [TS_W-1:0]  ts_data,
  output logic [CNT_W-1:0] bg_cnt,
  output logic [SUM_W-1:0] bg_sum,
  output logic [CNT_W-1:0] sig_cnt,
  output logic [SUM_W-1:0] sig_sum,
  output logic             ovf,
  output logic             rd_valid
);
  logic active, accept;
  logic [NUM_PHASES-1:0] hit, sat;
  logic [CNT_W-1:0] cnt_arr [NUM_PHASES];
  logic [SUM_W-1:0] sum_arr [NUM_PHASES];
  phase_e phase;

  assign phase = phase_e'(laser_on);

  frame_ctrl u_frame (
    .clk(clk), .rst_n(rst_n), .clr_i(frame_clr), .end_i(frame_end),
    .active_o(active), .done_o(rd_valid)
  );

  photon_gate u_gate (
    .clk(clk), .rst_n(rst_n), .clr_i(frame_clr), .active_i(active),
    .en_i(win_en), .valid_i(ts_valid), .accept_o(accept)
  );

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_pair
    assign hit[g] = accept & (phase == phase_e'(g));
    stat_pair #(.TS_W(TS_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_pair (
      .clk(clk), .rst_n(rst_n), .clr_i(frame_clr), .hit_i(hit[g]),
      .ts_i(ts_data), .cnt_o(cnt_arr[g]), .sum_o(sum_arr[g]), .sat_o(sat[g])
    );
  end

  assign bg_cnt  = cnt_arr[PH_BG];
  assign bg_sum  = sum_arr[PH_BG];
  assign sig_cnt = cnt_arr[PH_SIG];
  assign sig_sum = sum_arr[PH_SIG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ovf <= 1'b0;
    else if (frame_clr) ovf <= 1'b0;
    else if (|sat)      ovf <= 1'b1;
  end

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !frame_clr) |=> ovf);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !frame_clr) |=> ($stable(bg_cnt) && $stable(sig_sum)));
  // R3
  bg_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!ts_valid || laser_on) && !frame_clr) |=> ($stable(bg_cnt) && $stable(bg_sum)));
  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_clr |=> (bg_cnt == '0 && sig_cnt == '0 && !ovf && !rd_valid));
endmodule

// File: tb/test_pixel_stat_accum.sv
module test_pixel_stat_accum;
  localparam int CLK_PERIOD = 10;
  localparam int TS_W = 4, CNT_W = 5, SUM_W = 8;
  localparam int CMAX = (1 << CNT_W) - 1;
  localparam int SMAX = (1 << SUM_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_clr = 0, frame_end = 0, win_en = 0, laser_on = 0, ts_valid = 0;
  logic [TS_W-1:0] ts_data = '0;
  logic [CNT_W-1:0] bg_cnt, sig_cnt;
  logic [SUM_W-1:0] bg_sum, sig_sum;
  logic ovf, rd_valid;

  int n_chk = 0, n_fail = 0;
  int e_cnt [2];
  int e_sum [2];
  bit e_ovf;

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_stat_accum #(.TS_W(TS_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) i_pixel_stat_accum (
    .clk(clk), .rst_n(rst_n), .frame_clr(frame_clr), .frame_end(frame_end),
    .win_en(win_en), .laser_on(laser_on), .ts_valid(ts_valid), .ts_data(ts_data),
    .bg_cnt(bg_cnt), .bg_sum(bg_sum), .sig_cnt(sig_cnt), .sig_sum(sig_sum),
    .ovf(ovf), .rd_valid(rd_valid)
  );

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_hit(int ph, int ts);
    if (e_cnt[ph] == CMAX || e_sum[ph] + ts > SMAX) e_ovf = 1;
    if (e_cnt[ph] < CMAX) e_cnt[ph]++;
    e_sum[ph] = (e_sum[ph] + ts > SMAX) ? SMAX : e_sum[ph] + ts;
  endtask

  task automatic model_clr();
    e_cnt[0] = 0; e_cnt[1] = 0; e_sum[0] = 0; e_sum[1] = 0; e_ovf = 0;
  endtask

  task automatic tick(); @(negedge clk); endtask

  // One window: optional idle leading cycle, first photon, then extra strobes
  task automatic run(int ph, int ts, int extra, bit late, bit model);
    laser_on = ph[0];
    win_en = 1;
    if (late) begin ts_valid = 0; tick(); end
    ts_valid = 1; ts_data = ts[TS_W-1:0];
    tick();
    for (int k = 0; k < extra; k++) begin
      ts_data = TS_W'(ts ^ 4'hA); tick();
    end
    ts_valid = 0; win_en = 0;
    tick();
    if (model) model_hit(ph, ts);
  endtask

  task automatic pulse_clr(); frame_clr = 1; tick(); frame_clr = 0; model_clr(); endtask
  task automatic pulse_end(); frame_end = 1; tick(); frame_end = 0; endtask

  task automatic check_all(string tag);
    check({tag, " bg_cnt"}, int'(bg_cnt), e_cnt[0]);
    check({tag, " bg_sum"}, int'(bg_sum), e_sum[0]);
    check({tag, " sig_cnt"}, int'(sig_cnt), e_cnt[1]);
    check({tag, " sig_sum"}, int'(sig_sum), e_sum[1]);
    check({tag, " ovf"}, int'(ovf), int'(e_ovf));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    model_clr();
    tick(); tick();
    rst_n = 1;
    tick();
    // R9 reset state
    check_all("R9 reset");
    check("R9 rd_valid", int'(rd_valid), 0);

    // R8 idle before any frame: strobes ignored
    run(1, 7, 0, 0, 0);
    check_all("R8 pre-frame idle");

    // Sweep: R1 R2 R3 R4
    pulse_clr();
    check("R5 rd_valid low after clr", int'(rd_valid), 0);
    for (int t = 0; t < 16; t++) begin
      run(0, t, t % 3, t[0], 1);
      run(1, 15 - t, (t + 1) % 3, !t[0], 1);
    end
    pulse_end();
    check("R8 rd_valid after end", int'(rd_valid), 1);
    check_all("R1 R2 R3 R4 sweep");
    check("R4 bg_sum value", int'(bg_sum), 120);

    // R8 strobes after frame end ignored
    run(0, 5, 1, 0, 0);
    run(1, 9, 0, 1, 0);
    check_all("R8 post-frame idle");
    check("R8 rd_valid held", int'(rd_valid), 1);

    // R5 clear cycle collides with window-opening strobe
    pulse_clr();
    check_all("R5 clear");
    win_en = 1; laser_on = 1; ts_valid = 1; ts_data = 4'd6; frame_clr = 1;
    tick();
    frame_clr = 0; ts_valid = 0; win_en = 0;
    tick();
    check_all("R5 strobe in clr cycle dropped");
    run(1, 3, 0, 0, 1);
    check_all("R5 R2 first event after clr");

    // R6 R7 saturation on signal pair, background untouched
    pulse_clr();
    for (int k = 0; k < 40; k++) run(1, 9, 0, k[0], 1);
    check("R6 sig_cnt saturated", int'(sig_cnt), CMAX);
    check("R6 sig_sum saturated", int'(sig_sum), SMAX);
    check("R7 ovf raised", int'(ovf), 1);
    run(0, 2, 2, 0, 1);
    check_all("R7 R3 ovf sticky bg intact");
    pulse_end();
    check("R8 rd_valid", int'(rd_valid), 1);
    pulse_clr();
    check_all("R5 clr after saturation");

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule